// File: doc/BRIEF.md
# Single-Transfer PCI Initiator Driven by Registers

This block lets a local processor run one PCI transaction at a time by writing a few registers. Software loads a target address and, for writes, a data word. It then writes one byte that packs the command code and the active-low byte enables. That byte write is the start signal. The block drives one address phase carrying the address and the command, then a data phase carrying the byte enables. The data phase lasts until the target signals ready or a timeout expires. Read data ends up in a result register, and completion is reported through a one-cycle pulse and sticky flags.

For type 0 configuration cycles, software picks the target device by setting one upper address bit. Bit 16 selects the first device, and further devices use the bits above it. The low bits give the register offset. The block clears the two lowest address bits for configuration commands and decodes the device-select bits into one select line per device. These lines are driven only during the address phase. Memory and I/O commands pass the address through untouched.

Top module: `pcii_initiator`

## Requirements
- R1: During and after reset the bus outputs, the device selects, `rd_data` and all status outputs are zero.
- R2: A write with `reg_sel` = 2 (command select) while idle makes the next cycle an address phase. In that cycle `bus_frame`=1, `bus_cbe` carries bits 3:0 of the written byte, `bus_ad_out` carries the formed address, and `busy`=1. `reg_sel` = 0 loads the address and `reg_sel` = 1 loads the write data.
- R3: The address phase lasts exactly one cycle. It is followed by a data phase in which `bus_irdy`=1 and `bus_cbe` carries bits 7:4 of the command byte, the active-low byte enables. The data phase continues until the transfer ends.
- R4: For a read command, meaning bit 0 of the command is 0 (for example 1010 configuration read, 0110 memory read, 0010 I/O read), `bus_ad_in` is captured into `rd_data` at the edge where `bus_trdy` is sampled high.
- R5: For a write command, meaning bit 0 is 1 (for example 1011 configuration write, 0111 memory write), `bus_ad_out` carries the write-data register during the data phase, and `rd_data` keeps its value.
- R6: For configuration commands 1010 and 1011, the address phase drives address bits 1:0 as 00. It also raises `bus_idsel[k]` exactly when address bit 16+k is set. For every other command the address is driven unchanged and `bus_idsel` stays zero.
- R7: If `bus_trdy` is low on 16 consecutive data-phase edges, the transfer ends at the 16th edge and `abort_flag` is set. If the command was a read, `rd_data` becomes 0xFFFFFFFF. A `bus_trdy` sampled on the 16th edge still completes the transfer normally.
- R8: The edge that ends a transfer raises `done_pulse` for exactly one cycle and sets `done_flag`. An accepted start write clears `done_flag`, `abort_flag` and `overrun_flag`.
- R9: A start write while busy is ignored and sets `overrun_flag`. Address and write-data register writes while busy are dropped, so the next transfer uses the earlier values.
- R10: `busy` is high from the cycle after the accepted start write until the transfer ends, and it is low when `done_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 address, 1 write data, 2 command byte (start) |
| reg_wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Read result register |
| busy | output | 1 | Transfer in progress |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_flag | output | 1 | Sticky completion |
| abort_flag | output | 1 | Sticky timeout (master abort) |
| overrun_flag | output | 1 | Sticky start-while-busy |
| bus_frame | output | 1 | Address phase valid |
| bus_irdy | output | 1 | Data phase valid |
| bus_ad_out | output | 32 | Address/data driven to the bus |
| bus_cbe | output | 4 | Command in address phase, byte enables in data phase |
| bus_idsel | output | 4 | Per-device configuration select |
| bus_ad_in | input | 32 | Read data from target |
| bus_trdy | input | 1 | Target ready |

## Verification
The assertions assume that `bus_trdy` matters only while `bus_irdy` is high, and that `reg_sel` value 3 is never meaningful. The stimulus raises target ready only inside a data phase and drops it again right after the completing edge. It uses only the three defined select codes. Stimulus changes at the falling edge, so every rising edge samples stable inputs.

// File: rtl/pcii_pkg.sv
package pcii_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } pcii_state_e;

   typedef enum logic [1:0] {
      SEL_ADDR  = 2'd0,
      SEL_WDATA = 2'd1,
      SEL_CMD   = 2'd2
   } pcii_sel_e;

   localparam logic [3:0] CMD_CFG_RD = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR = 4'b1011;

   function automatic logic is_cfg(input logic [3:0] cmd);
      return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
   endfunction

   function automatic logic is_write(input logic [3:0] cmd);
      return cmd[0];
   endfunction

endpackage

// File: rtl/pcii_addr_form.sv
module pcii_addr_form
   import pcii_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int DEV_COUNT = 4,
   parameter int IDSEL_LSB = 16
) (
   input  logic [BUS_W-1:0]     addr_in,
   input  logic [3:0]           cmd,
   output logic [BUS_W-1:0]     addr_out,
   output logic [DEV_COUNT-1:0] idsel
);

   localparam int IDSEL_MSB = IDSEL_LSB + DEV_COUNT - 1;

   if (IDSEL_MSB >= BUS_W || IDSEL_LSB < 11 || DEV_COUNT < 1) begin : g_bad_cfg
      $error("pcii_addr_form: device-select field does not fit the address");
   end

   logic cfg;
   assign cfg = is_cfg(cmd);

   always_comb begin
      addr_out = addr_in;
      if (cfg) addr_out[1:0] = 2'b00;
   end

   for (genvar g = 0; g < DEV_COUNT; g++) begin : g_idsel
      assign idsel[g] = cfg & addr_in[IDSEL_LSB + g];
   end

endmodule

// File: rtl/pcii_abort_timer.sv
module pcii_abort_timer #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic trdy,
   output logic expire
);

   localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("pcii_abort_timer: TIMEOUT must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!run || trdy)      cnt <= '0;
      else if (cnt != LAST)       cnt <= cnt + 1'b1;
   end

   assign expire = run & ~trdy & (cnt == LAST);

   a_r7_count_resets_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/pcii_initiator.sv
module pcii_initiator
   import pcii_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int DEV_COUNT = 4,
   parameter int IDSEL_LSB = 16,
   parameter int TIMEOUT   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_en,
   input  logic [1:0]           reg_sel,
   input  logic [BUS_W-1:0]     reg_wr_data,
   output logic [BUS_W-1:0]     rd_data,
   output logic                 busy,
   output logic                 done_pulse,
   output logic                 done_flag,
   output logic                 abort_flag,
   output logic                 overrun_flag,
   output logic                 bus_frame,
   output logic                 bus_irdy,
   output logic [BUS_W-1:0]     bus_ad_out,
   output logic [3:0]           bus_cbe,
   output logic [DEV_COUNT-1:0] bus_idsel,
   input  logic [BUS_W-1:0]     bus_ad_in,
   input  logic                 bus_trdy
);

   if (BUS_W < 8) begin : g_bad_width
      $error("pcii_initiator: bus must be at least one byte wide");
   end

   pcii_state_e       state;
   logic [BUS_W-1:0]  addr_q, wdata_q, rd_q;
   logic [3:0]        cmd_q, be_n_q;
   logic              done_p, done_s, abort_s, ovr_s;
   logic              trig, accept, complete, expire, in_data;
   logic [BUS_W-1:0]  formed_addr;
   logic [DEV_COUNT-1:0] sel_lines;

   assign busy     = (state != ST_IDLE);
   assign in_data  = (state == ST_DATA);
   assign trig     = reg_wr_en && (reg_sel == SEL_CMD);
   assign accept   = trig && !busy;
   assign complete = in_data && (bus_trdy || expire);

   pcii_addr_form #(
      .BUS_W(BUS_W), .DEV_COUNT(DEV_COUNT), .IDSEL_LSB(IDSEL_LSB)
   ) u_form (
      .addr_in(addr_q), .cmd(cmd_q), .addr_out(formed_addr), .idsel(sel_lines)
   );

   pcii_abort_timer #(.TIMEOUT(TIMEOUT)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(in_data), .trdy(bus_trdy), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rd_q    <= '0;
         cmd_q   <= '0;
         be_n_q  <= '0;
         done_p  <= 1'b0;
         done_s  <= 1'b0;
         abort_s <= 1'b0;
         ovr_s   <= 1'b0;
      end else begin
         done_p <= complete;
         unique case (state)
            ST_IDLE: if (accept)   state <= ST_ADDR;
            ST_ADDR:               state <= ST_DATA;
            ST_DATA: if (complete) state <= ST_IDLE;
            default:               state <= ST_IDLE;
         endcase
         if (reg_wr_en && !busy && reg_sel == SEL_ADDR)  addr_q  <= reg_wr_data;
         if (reg_wr_en && !busy && reg_sel == SEL_WDATA) wdata_q <= reg_wr_data;
         if (accept) begin
            cmd_q   <= reg_wr_data[3:0];
            be_n_q  <= reg_wr_data[7:4];
            done_s  <= 1'b0;
            abort_s <= 1'b0;
            ovr_s   <= 1'b0;
         end
         if (trig && busy) ovr_s <= 1'b1;
         if (complete) begin
            done_s <= 1'b1;
            if (!bus_trdy) abort_s <= 1'b1;
            if (!is_write(cmd_q)) rd_q <= bus_trdy ? bus_ad_in : '1;
         end
      end
   end

   always_comb begin
      bus_frame  = (state == ST_ADDR);
      bus_irdy   = in_data;
      bus_cbe    = 4'h0;
      bus_ad_out = '0;
      bus_idsel  = '0;
      if (state == ST_ADDR) begin
         bus_cbe    = cmd_q;
         bus_ad_out = formed_addr;
         bus_idsel  = sel_lines;
      end else if (in_data) begin
         bus_cbe = be_n_q;
         if (is_write(cmd_q)) bus_ad_out = wdata_q;
      end
   end

   assign rd_data      = rd_q;
   assign done_pulse   = done_p;
   assign done_flag    = done_s;
   assign abort_flag   = abort_s;
   assign overrun_flag = ovr_s;

   a_r2_start_gives_addr_phase : assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !busy) |=> (bus_frame && busy));

   a_r3_addr_phase_single : assert property (@(posedge clk) disable iff (!rst_n)
      bus_frame |=> (!bus_frame && bus_irdy));

   a_r3_data_held : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_irdy && !bus_trdy && !expire) |=> bus_irdy);

   a_r4_result_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !done_pulse |-> $stable(rd_data));

   a_r6_cfg_low_bits : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_frame && is_cfg(bus_cbe)) |-> (bus_ad_out[1:0] == 2'b00));

   a_r7_timeout_aborts : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (abort_flag && !busy));

   a_r8_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   a_r10_idle_at_done : assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (done_flag && !busy));

   a_r9_overrun_sets : assert property (@(posedge clk) disable iff (!rst_n)
      (trig && busy) |=> overrun_flag);

endmodule

// File: tb/tb_pcii_initiator.sv
module tb_pcii_initiator;
   import pcii_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] rd_data;
   logic        busy, done_pulse, done_flag, abort_flag, overrun_flag;
   logic        bus_frame, bus_irdy;
   logic [31:0] bus_ad_out;
   logic [3:0]  bus_cbe;
   logic [3:0]  bus_idsel;
   logic [31:0] bus_ad_in = '0;
   logic        bus_trdy = 1'b0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pcii_initiator dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
      .reg_wr_data(reg_wr_data), .rd_data(rd_data), .busy(busy),
      .done_pulse(done_pulse), .done_flag(done_flag), .abort_flag(abort_flag),
      .overrun_flag(overrun_flag), .bus_frame(bus_frame), .bus_irdy(bus_irdy),
      .bus_ad_out(bus_ad_out), .bus_cbe(bus_cbe), .bus_idsel(bus_idsel),
      .bus_ad_in(bus_ad_in), .bus_trdy(bus_trdy)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [7:0]  cbe;
      logic [3:0]  dly;
      logic [31:0] din;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{32'h0001_0010, 32'h0000_0000, 8'h0A, 4'd0,  32'hFC00_0008},
      '{32'h0002_0013, 32'hA000_0000, 8'h3B, 4'd2,  32'h5555_5555},
      '{32'h8000_1003, 32'h0000_0000, 8'h06, 4'd15, 32'h1234_5678},
      '{32'h0000_C002, 32'hDEAD_BEEF, 8'hF7, 4'd1,  32'h6666_6666},
      '{32'h0008_0011, 32'h0000_0000, 8'h52, 4'd3,  32'h0BAD_F00D},
      '{32'h0008_0004, 32'h0000_0000, 8'h0A, 4'd0,  32'h1111_2222}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr_en   = 1'b1;
      reg_sel     = sel;
      reg_wr_data = data;
      @(negedge clk);
      reg_wr_en   = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] exp_rd;
      logic [31:0] exp_addr;
      logic [3:0]  exp_sel;
      logic [3:0]  cmd;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", {31'd0, busy}, 32'd0);
      chk("R1 rd_data in reset", rd_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 bus after reset", {bus_frame, bus_irdy, bus_cbe, bus_idsel}, 32'd0);
      chk("R1 flags after reset", {done_pulse, done_flag, abort_flag, overrun_flag}, 32'd0);
      chk("R1 ad_out after reset", bus_ad_out, 32'd0);

      exp_rd = 32'd0;
      for (int i = 0; i < NV; i++) begin
         cmd = VECS[i].cbe[3:0];
         exp_addr = VECS[i].addr;
         exp_sel  = 4'd0;
         if (cmd == 4'b1010 || cmd == 4'b1011) begin
            exp_addr[1:0] = 2'b00;
            exp_sel = VECS[i].addr[19:16];
         end
         wr(SEL_ADDR, VECS[i].addr);
         wr(SEL_WDATA, VECS[i].wdata);
         wr(SEL_CMD, {24'd0, VECS[i].cbe});
         // address phase
         chk("R2 frame", {31'd0, bus_frame}, 32'd1);
         chk("R10 busy", {31'd0, busy}, 32'd1);
         chk("R2 command on cbe", {28'd0, bus_cbe}, {28'd0, cmd});
         chk("R6 address", bus_ad_out, exp_addr);
         chk("R6 idsel", {28'd0, bus_idsel}, {28'd0, exp_sel});
         chk("R8 done_flag cleared", {31'd0, done_flag}, 32'd0);
         @(negedge clk);
         // data phase
         chk("R3 irdy no frame", {30'd0, bus_frame, bus_irdy}, 32'd1);
         chk("R3 byte enables", {28'd0, bus_cbe}, {28'd0, VECS[i].cbe[7:4]});
         if (cmd[0]) chk("R5 write data", bus_ad_out, VECS[i].wdata);
         repeat (int'(VECS[i].dly)) @(negedge clk);
         chk("R3 irdy held", {31'd0, bus_irdy}, 32'd1);
         bus_trdy  = 1'b1;
         bus_ad_in = VECS[i].din;
         @(negedge clk);
         bus_trdy  = 1'b0;
         if (!cmd[0]) exp_rd = VECS[i].din;
         chk(cmd[0] ? "R5 rd_data kept" : "R4 rd_data captured", rd_data, exp_rd);
         chk("R8 done pulse and flag", {30'd0, done_pulse, done_flag}, 32'd3);
         chk("R10 busy low at done", {31'd0, busy}, 32'd0);
         chk("R7 no abort", {31'd0, abort_flag}, 32'd0);
         @(negedge clk);
         chk("R8 pulse one cycle", {30'd0, done_pulse, done_flag}, 32'd1);
      end

      // R7 timeout on a configuration read
      wr(SEL_ADDR, 32'h0004_0008);
      wr(SEL_CMD, 32'h0000_000A);
      @(negedge clk);
      repeat (15) @(negedge clk);
      chk("R7 still busy at 15 waits", {31'd0, busy}, 32'd1);
      @(negedge clk);
      chk("R7 aborted", {30'd0, abort_flag, busy}, 32'd2);
      chk("R7 all ones", rd_data, 32'hFFFF_FFFF);
      chk("R8 done on abort", {31'd0, done_pulse}, 32'd1);

      // R9 overrun and dropped writes while busy
      wr(SEL_ADDR, 32'h0001_0004);
      wr(SEL_CMD, 32'h0000_0006);
      chk("R8 abort cleared by start", {31'd0, abort_flag}, 32'd0);
      @(negedge clk);
      wr(SEL_CMD, 32'h0000_000A);
      wr(SEL_ADDR, 32'h1234_5678);
      chk("R9 overrun set", {31'd0, overrun_flag}, 32'd1);
      chk("R9 transfer continues", {31'd0, bus_irdy}, 32'd1);
      chk("R9 cbe unchanged", {28'd0, bus_cbe}, 32'd0);
      bus_trdy = 1'b1;
      bus_ad_in = 32'hCAFE_0001;
      @(negedge clk);
      bus_trdy = 1'b0;
      chk("R9 ignored start left no extra transfer", rd_data, 32'hCAFE_0001);
      repeat (2) @(negedge clk);
      chk("R9 stays idle", {30'd0, bus_frame, busy}, 32'd0);
      wr(SEL_CMD, 32'h0000_0006);
      chk("R9 address write dropped", bus_ad_out, 32'h0001_0004);
      chk("R8 overrun cleared by start", {31'd0, overrun_flag}, 32'd0);
      @(negedge clk);
      bus_trdy = 1'b1;
      bus_ad_in = 32'hCAFE_0002;
      @(negedge clk);
      bus_trdy = 1'b0;
      chk("R4 final read", rd_data, 32'hCAFE_0002);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule